// File: doc/BRIEF.md
# Sliding Window Generator

This block turns a raster stream of 16-bit grayscale pixels into complete two-dimensional windows for a window-processing datapath, such as absolute-difference, convolution or correntropy kernels. Pixels enter one per cycle through a valid/ready handshake. Each image row is written into one of N row memories, which are used in rotation. Once N rows are stored, the block reads one column of N pixels per cycle from all memories at once. Each column is shifted into an N×M register file, so a full window leaves the block on every cycle of the sweep.

When the sweep of a row band is finished, the oldest row is retired. Its memory then takes the next image row, and the register file starts again from the leftmost window of the next band. The image width and height, the window size and the pixel width are elaboration parameters. Each output window carries its top-left row and column. An end-of-frame flag is set on the last window of an image. The block accepts the next frame at once.

Top module: `swg_window_gen`

## Requirements
- R1: While reset is applied and the synchronized reset is still releasing, `pix_ready_o`, `win_valid_o` and `win_eof_o` are low.
- R2: Each window is ordered row-major on `win_o`. Element (i, j) sits at bits [(i*WIN_M+j)*PIX_W +: PIX_W] and equals image pixel (row + i, column + j), where row and column are the values reported on `win_row_o` and `win_col_o`.
- R3: Within a band, the windows appear on consecutive cycles. Their columns run 0, 1, … IMG_W−WIN_M, one per cycle, with no gap.
- R4: A frame yields exactly IMG_H−WIN_N+1 bands, whose rows run 0 … IMG_H−WIN_N in order. That is (IMG_H−WIN_N+1)·(IMG_W−WIN_M+1) windows in total, and no window appears outside a frame.
- R5: `win_eof_o` is high on the last window of a frame (row IMG_H−WIN_N, column IMG_W−WIN_M) and at no other time.
- R6: After the handshake of the last pixel of a row that completes a band (row index ≥ WIN_N−1), `pix_ready_o` is low for exactly IMG_W cycles, then high again. The row memories are never written and read in the same cycle.
- R7: No window is produced before its band is fully stored. When the first window of band b of a frame appears, exactly (b+WIN_N)·IMG_W pixels of that frame have been accepted.
- R8: Frames follow back to back with no reset between them. Each frame's windows hold only that frame's pixels, and input stalls (`pix_valid_i` low) do not disturb the windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pix_i | input | PIX_W | Incoming pixel, raster order |
| pix_valid_i | input | 1 | `pix_i` holds a pixel |
| pix_ready_o | output | 1 | Block can store a pixel this cycle |
| win_o | output | WIN_N·WIN_M·PIX_W | Flattened window, row-major, element (0,0) in the low bits |
| win_valid_o | output | 1 | `win_o` holds a complete window |
| win_row_o | output | clog2(IMG_H) | Image row of the window's top-left pixel |
| win_col_o | output | clog2(IMG_W) | Image column of the window's top-left pixel |
| win_eof_o | output | 1 | Last window of the frame |

## Verification
The assertions assume that the input obeys the handshake. A pixel counts only when valid and ready are both high, and the source keeps strict raster order with whole frames of IMG_W·IMG_H pixels. Under that assumption the column stepping, band stepping, end-of-frame placement and read/write exclusion must hold. The stimulus always presents the next raster pixel and advances only on a completed handshake. Frames are sent back to back, one of them with periodic valid gaps. This keeps the stimulus inside the assumption while testing that stalls and frame boundaries leave the windows intact. Pixel values come from a formula of frame, row and column, so every window element can be predicted in the bench.

// File: rtl/swg_pkg.sv
package swg_pkg;

  typedef enum logic {
    ST_FILL = 1'b0,
    ST_SCAN = 1'b1
  } swg_state_e;

endpackage

// File: rtl/swg_row_mem.sv
module swg_row_mem #(
  parameter int PIX_W = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [PIX_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [PIX_W-1:0] rd_data_o
);

  logic [PIX_W-1:0] store_q [DEPTH];
  logic [PIX_W-1:0] rd_d;

  // storage array: write port only, no reset
  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      store_q[wr_addr_i] <= wr_data_i;
    end
  end

  // registered read port
  always_comb begin
    rd_d = rd_data_o;
    if (rd_en_i) begin
      rd_d = store_q[rd_addr_i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_o <= '0;
    end else begin
      rd_data_o <= rd_d;
    end
  end

endmodule

// File: rtl/swg_ctrl.sv
module swg_ctrl
  import swg_pkg::*;
#(
  parameter int IMG_W = 8,
  parameter int IMG_H = 8,
  parameter int WIN_N = 3,
  localparam int CW   = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int RW   = (IMG_H > 1) ? $clog2(IMG_H) : 1,
  localparam int SW   = (WIN_N > 1) ? $clog2(WIN_N) : 1,
  localparam int HW   = $clog2(WIN_N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid_i,
  output logic             pix_ready_o,
  output logic [WIN_N-1:0] wr_en_o,
  output logic [CW-1:0]    wr_addr_o,
  output logic             rd_en_o,
  output logic [CW-1:0]    rd_addr_o,
  output logic             col_vld_o,
  output logic [CW-1:0]    col_idx_o,
  output logic [RW-1:0]    col_band_o,
  output logic [SW-1:0]    col_top_o
);

  localparam logic [CW-1:0] LAST_COL  = CW'(IMG_W - 1);
  localparam logic [RW-1:0] LAST_BAND = RW'(IMG_H - WIN_N);
  localparam logic [SW-1:0] LAST_SLOT = SW'(WIN_N - 1);
  localparam logic [HW-1:0] FULL_CNT  = HW'(WIN_N);

  swg_state_e      state_q, state_d;
  logic            live_q;
  logic [CW-1:0]   wr_col_q, wr_col_d;
  logic [SW-1:0]   wr_slot_q, wr_slot_d;
  logic [HW-1:0]   held_q, held_d;
  logic [RW-1:0]   band_q, band_d;
  logic [SW-1:0]   top_q, top_d;
  logic [CW-1:0]   rd_col_q, rd_col_d;
  logic            accept;
  logic            scan_en;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    wr_col_d  = wr_col_q;
    wr_slot_d = wr_slot_q;
    held_d    = held_q;
    band_d    = band_q;
    top_d     = top_q;
    rd_col_d  = rd_col_q;

    pix_ready_o = live_q && (state_q == ST_FILL);
    accept      = pix_ready_o && pix_valid_i;
    scan_en     = live_q && (state_q == ST_SCAN);

    if (accept) begin
      if (wr_col_q == LAST_COL) begin
        wr_col_d  = '0;
        wr_slot_d = (wr_slot_q == LAST_SLOT) ? '0 : wr_slot_q + 1'b1;
        held_d    = held_q + 1'b1;
        if (held_q + 1'b1 == FULL_CNT) begin
          state_d  = ST_SCAN;
          rd_col_d = '0;
        end
      end else begin
        wr_col_d = wr_col_q + 1'b1;
      end
    end

    if (scan_en) begin
      rd_col_d = rd_col_q + 1'b1;
      if (rd_col_q == LAST_COL) begin
        rd_col_d = '0;
        state_d  = ST_FILL;
        if (band_q == LAST_BAND) begin
          band_d    = '0;
          top_d     = '0;
          wr_slot_d = '0;
          held_d    = '0;
        end else begin
          band_d = band_q + 1'b1;
          top_d  = (top_q == LAST_SLOT) ? '0 : top_q + 1'b1;
          held_d = HW'(WIN_N - 1);
        end
      end
    end
  end

  // write strobes: one-hot on the slot being filled
  for (genvar s = 0; s < WIN_N; s++) begin : g_wr_en
    assign wr_en_o[s] = accept && (wr_slot_q == SW'(s));
  end

  assign wr_addr_o = wr_col_q;
  assign rd_en_o   = scan_en;
  assign rd_addr_o = rd_col_q;

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_FILL;
      live_q    <= 1'b0;
      wr_col_q  <= '0;
      wr_slot_q <= '0;
      held_q    <= '0;
      band_q    <= '0;
      top_q     <= '0;
      rd_col_q  <= '0;
    end else begin
      state_q   <= state_d;
      live_q    <= 1'b1;
      wr_col_q  <= wr_col_d;
      wr_slot_q <= wr_slot_d;
      held_q    <= held_d;
      band_q    <= band_d;
      top_q     <= top_d;
      rd_col_q  <= rd_col_d;
    end
  end

  // read pipeline tags, aligned with the memory read data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_vld_o  <= 1'b0;
      col_idx_o  <= '0;
      col_band_o <= '0;
      col_top_o  <= '0;
    end else begin
      col_vld_o <= scan_en;
      if (scan_en) begin
        col_idx_o  <= rd_col_q;
        col_band_o <= band_q;
        col_top_o  <= top_q;
      end
    end
  end

  AST_SCAN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && rd_col_q == LAST_COL) |=> (state_q == ST_FILL)); // R6

  AST_BAND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (band_q == $past(band_q) || band_q == $past(band_q) + 1'b1 || band_q == '0)); // R4

  AST_PRIMED_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> (held_q == FULL_CNT)); // R7

endmodule

// File: rtl/swg_window_regs.sv
module swg_window_regs #(
  parameter int PIX_W = 16,
  parameter int IMG_W = 8,
  parameter int IMG_H = 8,
  parameter int WIN_N = 3,
  parameter int WIN_M = 3,
  localparam int CW   = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int RW   = (IMG_H > 1) ? $clog2(IMG_H) : 1,
  localparam int SW   = (WIN_N > 1) ? $clog2(WIN_N) : 1,
  localparam int BUSW = WIN_N * WIN_M * PIX_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   col_vld_i,
  input  logic [CW-1:0]          col_idx_i,
  input  logic [RW-1:0]          col_band_i,
  input  logic [SW-1:0]          col_top_i,
  input  logic [WIN_N*PIX_W-1:0] slot_data_i,
  output logic [BUSW-1:0]        win_o,
  output logic                   win_valid_o,
  output logic [RW-1:0]          win_row_o,
  output logic [CW-1:0]          win_col_o,
  output logic                   win_eof_o
);

  localparam logic [CW-1:0] FIRST_FULL = CW'(WIN_M - 1);
  localparam logic [CW-1:0] LAST_COL   = CW'(IMG_W - 1);
  localparam logic [CW-1:0] LAST_WCOL  = CW'(IMG_W - WIN_M);
  localparam logic [RW-1:0] LAST_BAND  = RW'(IMG_H - WIN_N);

  logic [PIX_W-1:0] col_pix [WIN_N];
  logic [PIX_W-1:0] win_q [WIN_N][WIN_M];
  logic [PIX_W-1:0] win_d [WIN_N][WIN_M];
  logic             valid_d, eof_d;
  logic [RW-1:0]    row_d;
  logic [CW-1:0]    col_d;

  // rotate memory slots into window row order: row i comes from slot top+i
  for (genvar i = 0; i < WIN_N; i++) begin : g_rot
    logic [SW:0] slot_sum;
    logic [SW:0] slot_sel;
    always_comb begin
      slot_sum   = {1'b0, col_top_i} + (SW+1)'(i);
      slot_sel   = (slot_sum >= (SW+1)'(WIN_N)) ? slot_sum - (SW+1)'(WIN_N) : slot_sum;
      col_pix[i] = slot_data_i[slot_sel*PIX_W +: PIX_W];
    end
  end

  // shift a new column into the right edge of the register file
  always_comb begin
    win_d = win_q;
    if (col_vld_i) begin
      for (int i = 0; i < WIN_N; i++) begin
        for (int j = 0; j < WIN_M - 1; j++) begin
          win_d[i][j] = win_q[i][j+1];
        end
        win_d[i][WIN_M-1] = col_pix[i];
      end
    end
  end

  always_comb begin
    valid_d = col_vld_i && (col_idx_i >= FIRST_FULL);
    eof_d   = col_vld_i && (col_idx_i == LAST_COL) && (col_band_i == LAST_BAND);
    row_d   = win_row_o;
    col_d   = win_col_o;
    if (col_vld_i) begin
      row_d = col_band_i;
      col_d = col_idx_i - FIRST_FULL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN_N; i++) begin
        for (int j = 0; j < WIN_M; j++) begin
          win_q[i][j] <= '0;
        end
      end
      win_valid_o <= 1'b0;
      win_eof_o   <= 1'b0;
      win_row_o   <= '0;
      win_col_o   <= '0;
    end else begin
      win_q       <= win_d;
      win_valid_o <= valid_d;
      win_eof_o   <= eof_d;
      win_row_o   <= row_d;
      win_col_o   <= col_d;
    end
  end

  for (genvar i = 0; i < WIN_N; i++) begin : g_out_r
    for (genvar j = 0; j < WIN_M; j++) begin : g_out_c
      assign win_o[(i*WIN_M+j)*PIX_W +: PIX_W] = win_q[i][j];
    end
  end

  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid_o && win_col_o != LAST_WCOL) |=>
      (win_valid_o && win_col_o == $past(win_col_o) + 1'b1)); // R3

  AST_EOF_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    win_eof_o |-> (win_valid_o && win_col_o == LAST_WCOL && win_row_o == LAST_BAND)); // R5

  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> (win_row_o <= LAST_BAND)); // R4

endmodule

// File: rtl/swg_window_gen.sv
module swg_window_gen #(
  parameter int PIX_W = 16,
  parameter int IMG_W = 8,
  parameter int IMG_H = 8,
  parameter int WIN_N = 3,
  parameter int WIN_M = 3,
  localparam int CW   = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int RW   = (IMG_H > 1) ? $clog2(IMG_H) : 1,
  localparam int SW   = (WIN_N > 1) ? $clog2(WIN_N) : 1,
  localparam int BUSW = WIN_N * WIN_M * PIX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             pix_valid_i,
  output logic             pix_ready_o,
  output logic [BUSW-1:0]  win_o,
  output logic             win_valid_o,
  output logic [RW-1:0]    win_row_o,
  output logic [CW-1:0]    win_col_o,
  output logic             win_eof_o
);

  logic                   rst_meta_q, rst_sync_q;
  logic [WIN_N-1:0]       wr_en;
  logic [CW-1:0]          wr_addr;
  logic                   rd_en;
  logic [CW-1:0]          rd_addr;
  logic                   col_vld;
  logic [CW-1:0]          col_idx;
  logic [RW-1:0]          col_band;
  logic [SW-1:0]          col_top;
  logic [WIN_N*PIX_W-1:0] slot_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  swg_ctrl #(
    .IMG_W (IMG_W),
    .IMG_H (IMG_H),
    .WIN_N (WIN_N)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .pix_valid_i (pix_valid_i),
    .pix_ready_o (pix_ready_o),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .rd_en_o     (rd_en),
    .rd_addr_o   (rd_addr),
    .col_vld_o   (col_vld),
    .col_idx_o   (col_idx),
    .col_band_o  (col_band),
    .col_top_o   (col_top)
  );

  for (genvar s = 0; s < WIN_N; s++) begin : g_rowmem
    swg_row_mem #(
      .PIX_W (PIX_W),
      .DEPTH (IMG_W)
    ) u_mem (
      .clk       (clk),
      .rst_n     (rst_sync_q),
      .wr_en_i   (wr_en[s]),
      .wr_addr_i (wr_addr),
      .wr_data_i (pix_i),
      .rd_en_i   (rd_en),
      .rd_addr_i (rd_addr),
      .rd_data_o (slot_data[s*PIX_W +: PIX_W])
    );
  end

  swg_window_regs #(
    .PIX_W (PIX_W),
    .IMG_W (IMG_W),
    .IMG_H (IMG_H),
    .WIN_N (WIN_N),
    .WIN_M (WIN_M)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .col_vld_i   (col_vld),
    .col_idx_i   (col_idx),
    .col_band_i  (col_band),
    .col_top_i   (col_top),
    .slot_data_i (slot_data),
    .win_o       (win_o),
    .win_valid_o (win_valid_o),
    .win_row_o   (win_row_o),
    .win_col_o   (win_col_o),
    .win_eof_o   (win_eof_o)
  );

  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !((|wr_en) && rd_en)); // R6

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $onehot0(wr_en)); // R8

endmodule

// File: tb/sim_swg_window_gen.sv
module sim_swg_window_gen;

  localparam int P  = 16;
  localparam int W  = 8;
  localparam int H  = 8;
  localparam int N  = 3;
  localparam int M  = 3;
  localparam int NF = 3;
  localparam int CW = 3;
  localparam int RW = 3;
  localparam int LIMIT = 20000;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [P-1:0]     pix_i;
  logic             pix_valid_i;
  logic             pix_ready_o;
  logic [N*M*P-1:0] win_o;
  logic             win_valid_o;
  logic [RW-1:0]    win_row_o;
  logic [CW-1:0]    win_col_o;
  logic             win_eof_o;

  always #10 clk = ~clk;

  swg_window_gen #(
    .PIX_W (P), .IMG_W (W), .IMG_H (H), .WIN_N (N), .WIN_M (M)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .pix_i (pix_i), .pix_valid_i (pix_valid_i),
    .pix_ready_o (pix_ready_o), .win_o (win_o), .win_valid_o (win_valid_o),
    .win_row_o (win_row_o), .win_col_o (win_col_o), .win_eof_o (win_eof_o)
  );

  int n_checks = 0;
  int n_fail   = 0;

  function automatic logic [P-1:0] pix_val(int f, int r, int c);
    return P'(f * 29489 + r * 293 + c * 17 + 32768);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    int  cyc = 0;
    int  sent = 0;
    int  mf = 0, er = 0, ec = 0;
    int  wins = 0;
    int  last_vcyc = -10;
    int  stall_left = 0;
    bit  expect_high = 0;
    bit  v;

    rst_n = 1'b0;
    pix_valid_i = 1'b0;
    pix_i = '0;
    repeat (4) begin
      @(negedge clk);
      check(pix_ready_o == 1'b0, "R1", "ready in reset", int'(pix_ready_o), 0);
      check(win_valid_o == 1'b0 && win_eof_o == 1'b0, "R1", "valid/eof in reset",
            int'(win_valid_o), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check(pix_ready_o == 1'b0, "R1", "ready during reset release", int'(pix_ready_o), 0);

    while (mf < NF && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;

      // output monitor
      if (win_valid_o) begin
        bit ok = 1;
        int bad_a = 0, bad_e = 0;
        for (int i = 0; i < N; i++) begin
          for (int j = 0; j < M; j++) begin
            if (ok && win_o[(i*M+j)*P +: P] != pix_val(mf, er + i, ec + j)) begin
              ok = 0;
              bad_a = int'(win_o[(i*M+j)*P +: P]);
              bad_e = int'(pix_val(mf, er + i, ec + j));
            end
          end
        end
        check(ok, (mf > 0) ? "R8" : "R2", "window pixel", bad_a, bad_e);
        check(int'(win_row_o) == er, "R4", "window row", int'(win_row_o), er);
        check(int'(win_col_o) == ec, "R3", "window column", int'(win_col_o), ec);
        check(win_eof_o == (er == H - N && ec == W - M), "R5", "eof flag",
              int'(win_eof_o), int'(er == H - N && ec == W - M));
        if (ec > 0) begin
          check(last_vcyc == cyc - 1, "R3", "window gap", cyc - last_vcyc, 1);
        end else begin
          check(sent == mf * W * H + (er + N) * W, "R7", "pixels before band",
                sent, mf * W * H + (er + N) * W);
        end
        last_vcyc = cyc;
        wins++;
        if (ec == W - M) begin
          ec = 0;
          if (er == H - N) begin
            er = 0;
            mf++;
          end else begin
            er++;
          end
        end else begin
          ec++;
        end
      end else begin
        check(win_eof_o == 1'b0, "R5", "eof without valid", int'(win_eof_o), 0);
      end

      // input stall window after a band-completing row
      if (stall_left > 0) begin
        check(pix_ready_o == 1'b0, "R6", "ready during sweep", int'(pix_ready_o), 0);
        stall_left--;
        if (stall_left == 0) expect_high = 1;
      end else if (expect_high) begin
        check(pix_ready_o == 1'b1, "R6", "ready after sweep", int'(pix_ready_o), 1);
        expect_high = 0;
      end

      // driver: handshake completes at the next rising edge
      if (sent < NF * W * H) begin
        v = !((sent / (W * H)) == 1 && (cyc % 3 == 1));
      end else begin
        v = 0;
      end
      pix_valid_i = v;
      pix_i = pix_val(sent / (W * H), (sent / W) % H, sent % W);
      if (v && pix_ready_o) begin
        if ((sent % W) == W - 1 && ((sent / W) % H) >= N - 1) stall_left = W;
        sent++;
      end
    end

    pix_valid_i = 1'b0;
    check(cyc < LIMIT, "R4", "watchdog", cyc, LIMIT);
    check(wins == NF * (H - N + 1) * (W - M + 1), "R4", "total windows", wins,
          NF * (H - N + 1) * (W - M + 1));

    // no stray windows once all frames are done
    begin
      int extra = 0;
      repeat (30) begin
        @(negedge clk);
        if (win_valid_o) extra++;
      end
      check(extra == 0, "R4", "windows after last frame", extra, 0);
      check(pix_ready_o == 1'b1, "R6", "idle ready", int'(pix_ready_o), 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule